// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block performs lane-parallel addition or subtraction on two 64-bit operands that are split into independent sub-words. Every lane carries out the same operation on its own pair of elements, and no carry or borrow crosses from one lane into the next. A size control selects either eight 8-bit lanes or four 16-bit lanes. A mode control selects how results that leave the lane's range are handled: they can wrap around, clamp to the unsigned range, or clamp to the signed two's-complement range.

The unit is meant to sit in a media or signal-processing datapath. Pixel or sample arithmetic needs results pinned to the ends of the range rather than folded back into it. The inputs are sampled on a rising clock edge, and the result is registered, so it appears one cycle later. A per-lane flag vector marks the lanes whose result was clamped.

Top module: `simd_sat_addsub`

## Requirements
- R1: A synchronous active-high `rst` clears `res_o` and `sat_o` to zero at the next rising clock edge.
- R2: Operands and controls sampled at a rising edge produce their `res_o` and `sat_o` after that same edge, which is one cycle of latency.
- R3: `lane16_i`=0 selects eight 8-bit lanes, and lane i occupies bits [8i+7:8i]. `lane16_i`=1 selects four 16-bit lanes, lane i occupies bits [16i+15:16i], and `sat_o[7:4]` is 0.
- R4: No carry or borrow propagates from one lane into another in any mode.
- R5: `mode_i`=0 (wrap), and likewise the spare code 3, returns the low lane-width bits of the exact result and leaves all `sat_o` bits at 0.
- R6: With `mode_i`=1 (unsigned clamp) and addition, a lane sum above the lane maximum (255 or 65535) becomes all ones.
- R7: With `mode_i`=1 and subtraction, a lane result below zero becomes 0.
- R8: `mode_i`=2 (signed clamp) treats lanes as two's complement. A result above the most positive value becomes that value (+127 or +32767), and a result below the most negative value becomes that value (-128 or -32768).
- R9: `sub_i`=0 computes a+b per lane, and `sub_i`=1 computes a-b per lane.
- R10: `sat_o[i]` is 1 exactly when lane i's result was clamped by R6, R7 or R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand (subtrahend) |
| lane16_i | input | 1 | 0: 8-bit lanes, 1: 16-bit lanes |
| sub_i | input | 1 | 0: add, 1: subtract |
| mode_i | input | 2 | 0 wrap, 1 unsigned clamp, 2 signed clamp, 3 wrap |
| res_o | output | 64 | Registered packed result |
| sat_o | output | 8 | Registered per-lane clamp flags |

## Verification
Directed vectors place values at the range edges in single lanes: 0xFF+1, 0-1, 0x7F+1 and 0x80-1, together with their 16-bit counterparts. These separate the three modes, since the same inputs must wrap, clamp high or clamp low depending on `mode_i`. A vector such as 0x00FF+0x0001 is run at both lane sizes. This exposes any carry that leaks across a byte boundary, and shows whether the lane split is chosen correctly. A long run of random operands across all size, operation and mode combinations is checked against a reference function computed lane by lane with wide integers. This catches wrong overflow detection in the flags.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP = 2'd0,
    MODE_USAT = 2'd1,
    MODE_SSAT = 2'd2,
    MODE_SPARE = 2'd3
  } sat_mode_e;
endpackage

// File: rtl/sat_lane.sv
module sat_lane
  import simd_sat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  sat_mode_e    mode,
  output logic [W-1:0] res,
  output logic         clamp
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] uext;
  logic [W:0] sext;

  always_comb begin
    uext = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    sext = sub ? ({a[W-1], a} - {b[W-1], b}) : ({a[W-1], a} + {b[W-1], b});
    res   = uext[W-1:0];
    clamp = 1'b0;
    unique case (mode)
      MODE_USAT: begin
        if (uext[W]) begin
          clamp = 1'b1;
          res   = sub ? '0 : '1;
        end
      end
      MODE_SSAT: begin
        if (sext[W] != sext[W-1]) begin
          clamp = 1'b1;
          res   = sext[W] ? SMIN : SMAX;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    // R6
    usat_add_clamp_chk: assert (!(clamp && mode == MODE_USAT && !sub) || res == '1);
    // R7
    usat_sub_clamp_chk: assert (!(clamp && mode == MODE_USAT && sub) || res == '0);
    // R8
    ssat_clamp_value_chk: assert (!(clamp && mode == MODE_SSAT) || res == SMIN || res == SMAX);
  end
endmodule

// File: rtl/lane_bank.sv
module lane_bank
  import simd_sat_pkg::*;
#(
  parameter int DW = 64,
  parameter int W  = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  sat_mode_e     mode,
  output logic [DW-1:0] res,
  output logic [DW/W-1:0] clamp
);
  localparam int NL = DW / W;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    sat_lane #(.W(W)) u_lane (
      .a    (a[i*W +: W]),
      .b    (b[i*W +: W]),
      .sub  (sub),
      .mode (mode),
      .res  (res[i*W +: W]),
      .clamp(clamp[i])
    );
  end
endmodule

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub
  import simd_sat_pkg::*;
#(
  parameter int DW = 64,
  parameter int NARROW = 8,
  parameter int WIDE = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        a_i,
  input  logic [DW-1:0]        b_i,
  input  logic                 lane16_i,
  input  logic                 sub_i,
  input  logic [1:0]           mode_i,
  output logic [DW-1:0]        res_o,
  output logic [DW/NARROW-1:0] sat_o
);
  localparam int NLN = DW / NARROW;
  localparam int NLW = DW / WIDE;

  sat_mode_e         mode;
  logic [DW-1:0]     res_n, res_w, res_d;
  logic [NLN-1:0]    clp_n, clp_d;
  logic [NLW-1:0]    clp_w;

  assign mode = sat_mode_e'(mode_i);

  lane_bank #(.DW(DW), .W(NARROW)) u_narrow (
    .a(a_i), .b(b_i), .sub(sub_i), .mode(mode), .res(res_n), .clamp(clp_n)
  );

  lane_bank #(.DW(DW), .W(WIDE)) u_wide (
    .a(a_i), .b(b_i), .sub(sub_i), .mode(mode), .res(res_w), .clamp(clp_w)
  );

  always_comb begin
    if (lane16_i) begin
      res_d = res_w;
      clp_d = '0;
      clp_d[NLW-1:0] = clp_w;
    end else begin
      res_d = res_n;
      clp_d = clp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      sat_o <= '0;
    end else begin
      res_o <= res_d;
      sat_o <= clp_d;
    end
  end

  // R5
  wrap_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0 || mode_i == 2'd3) |=> sat_o == '0);

  // R3
  wide_upper_flag_chk: assert property (@(posedge clk) disable iff (rst)
    lane16_i |=> sat_o[NLN-1:NLW] == '0);
endmodule

// File: tb/simd_sat_addsub_tb.sv
module simd_sat_addsub_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] a, b;
  logic        l16, sub;
  logic [1:0]  mode;
  logic [63:0] res;
  logic [7:0]  sat;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  simd_sat_addsub u_dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .lane16_i(l16),
    .sub_i(sub), .mode_i(mode), .res_o(res), .sat_o(sat)
  );

  function automatic logic [71:0] model(input logic [63:0] x, input logic [63:0] y,
                                        input logic sz, input logic s, input logic [1:0] m);
    logic [63:0] r = '0;
    logic [7:0]  f = '0;
    int w = sz ? 16 : 8;
    int n = sz ? 4 : 8;
    for (int i = 0; i < n; i++) begin
      longint ua = longint'((x >> (i*w)) & ((64'd1 << w) - 1));
      longint ub = longint'((y >> (i*w)) & ((64'd1 << w) - 1));
      longint umax = (longint'(1) << w) - 1;
      longint half = longint'(1) << (w-1);
      longint sa = (ua >= half) ? ua - (umax + 1) : ua;
      longint sb = (ub >= half) ? ub - (umax + 1) : ub;
      longint v;
      if (m == 2'd2) begin
        v = s ? sa - sb : sa + sb;
        if (v > half - 1) begin v = half - 1; f[i] = 1'b1; end
        else if (v < -half) begin v = -half; f[i] = 1'b1; end
      end else begin
        v = s ? ua - ub : ua + ub;
        if (m == 2'd1) begin
          if (v > umax) begin v = umax; f[i] = 1'b1; end
          else if (v < 0) begin v = 0; f[i] = 1'b1; end
        end
      end
      r = r | ((64'(v) & 64'(umax)) << (i*w));
    end
    return {f, r};
  endfunction

  task automatic check(input string tag, input logic [63:0] er, input logic [7:0] ef);
    compared++;
    if (res !== er || sat !== ef) begin
      mismatched++;
      $display("FAIL %s: res=%h sat=%b expected res=%h sat=%b", tag, res, sat, er, ef);
    end
  endtask

  task automatic run(input string tag, input logic [63:0] x, input logic [63:0] y,
                     input logic sz, input logic s, input logic [1:0] m);
    logic [71:0] e;
    a = x; b = y; l16 = sz; sub = s; mode = m;
    e = model(x, y, sz, s, m);
    @(posedge clk);
    @(negedge clk);
    check(tag, e[63:0], e[71:64]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: res=%h sat=%b expected completion", res, sat);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1'b1; a = '0; b = '0; l16 = 1'b0; sub = 1'b0; mode = 2'd0;
    a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h0101_0101_0101_0101; mode = 2'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 64'h0, 8'h0);
    rst = 1'b0;

    // R6 unsigned add clamp, single lane, and R10 flag position
    run("R6", 64'h0000_0000_00FF_0000, 64'h0000_0000_0001_0000, 1'b0, 1'b0, 2'd1);
    check("R10", 64'h0000_0000_00FF_0000, 8'b0000_0100);
    // R7 unsigned sub clamp
    run("R7", 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0, 1'b1, 2'd1);
    // R8 signed high and low
    run("R8 hi", 64'h0000_0000_0000_007F, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 2'd2);
    run("R8 lo", 64'h8000_0000_0000_0080, 64'h0001_0000_0000_0001, 1'b0, 1'b1, 2'd2);
    run("R8 16", 64'h7FFF_8000_0000_0000, 64'h0001_0001_0000_0000, 1'b1, 1'b0, 2'd2);
    // R4 carry does not cross byte lane; R3 wider lane lets it through
    run("R4", 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 2'd0);
    run("R3", 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 1'b1, 1'b0, 2'd0);
    run("R4 sub", 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001, 1'b0, 1'b1, 2'd0);
    // R5 wrap and spare code
    run("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1'b0, 1'b0, 2'd0);
    run("R5 spare", 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 1'b0, 1'b0, 2'd3);
    // R9 add vs subtract on same data
    run("R9 add", 64'h1020_3040_5060_7080, 64'h0102_0304_0506_0708, 1'b0, 1'b0, 2'd1);
    run("R9 sub", 64'h1020_3040_5060_7080, 64'h0102_0304_0506_0708, 1'b0, 1'b1, 2'd1);
    run("R6 16", 64'hFFFF_0000_0000_FFFF, 64'h0001_0000_0000_0002, 1'b1, 1'b0, 2'd1);
    // R2 back-to-back: each result follows its own inputs by one cycle
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      run("R2 random", x, y, 1'($urandom), 1'($urandom), 2'($urandom));
    end

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-run", 64'h0, 8'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule